// File: doc/BRIEF.md
# Conversion Sequencer with Early Interrupt and Window Comparators

This block sequences one successive-approximation conversion for each trigger pulse. A conversion runs for a fixed number of clocks. At its final clock edge the sequencer captures the converter's output word, which is modelled here as a plain data input. It then raises a one-cycle result-valid strobe. The conversion interrupt can be placed a programmable number of clocks ahead of that strobe. Control software can then enter its service routine while the last bits are still being resolved. Because every conversion takes the same number of clocks, the lead is exact.

Each completed word is also tested by a bank of window comparators. Each comparator holds an inclusive low and high limit and a polarity. It can flag words that land inside the window or words that land outside it. Software then runs only when a comparator reports a fault. A trigger that arrives while a conversion is running is dropped and sets a sticky overrun flag.

The controller is a two-state machine. In `ST_IDLE` no conversion is running. In `ST_CONV` a down-counter runs from CONV_CLKS-1 to zero. The machine has two transitions. START goes from `ST_IDLE` to `ST_CONV` when a trigger is seen. FINISH goes from `ST_CONV` back to `ST_IDLE` at the edge where the counter is zero; that edge is the capture edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_o, result_valid_o, conv_irq_o, overrun_o, cmp_fault_o and fault_irq_o are all 0.
- R2: A trig_i sampled high while idle starts a conversion. busy_o is 1 for exactly CONV_CLKS cycles, starting in the cycle after that edge.
- R3: result_valid_o is a one-cycle pulse that is high CONV_CLKS cycles after the trigger edge. result_o then holds the sample_data_i value present at the capture edge, and keeps it until the next capture.
- R4: With lead_en_i low at the trigger edge, conv_irq_o is a one-cycle pulse in the same cycle as result_valid_o.
- R5: With lead_en_i high at the trigger edge, conv_irq_o pulses L cycles before result_valid_o. L = min(lead_sel_i, LEAD_MAX, CONV_CLKS-1), with lead_sel_i read as an unsigned binary count of clocks. A lead value of 0 behaves as in R4.
- R6: lead_en_i and lead_sel_i are sampled only at the trigger edge. Changing them during a conversion has no effect on that conversion's interrupt timing.
- R7: A trig_i sampled high while busy_o is 1 is ignored, and the running conversion keeps its timing. It sets overrun_o, which stays 1 until reset.
- R8: Comparator k uses the limits cmp_lo_i[k*DATA_W +: DATA_W] and cmp_hi_i[k*DATA_W +: DATA_W], and a word is inside when lo <= word <= hi (both limits inclusive). When cmp_en_i[k] is 1, it fires if cmp_inside_i[k]=1 and the word is inside, or if cmp_inside_i[k]=0 and the word is outside. It never fires when cmp_en_i[k] is 0.
- R9: cmp_fault_o bits are one-cycle pulses that can occur only in the cycle result_valid_o is high. fault_irq_o is the OR of cmp_fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Conversion start request |
| lead_en_i | input | 1 | Enables the early interrupt lead |
| lead_sel_i | input | LEAD_W | Requested lead in clocks |
| sample_data_i | input | DATA_W | Converter output word, sampled at the capture edge |
| cmp_lo_i | input | NUM_CMP*DATA_W | Packed low limits, comparator k in slice k |
| cmp_hi_i | input | NUM_CMP*DATA_W | Packed high limits, comparator k in slice k |
| cmp_en_i | input | NUM_CMP | Comparator enables |
| cmp_inside_i | input | NUM_CMP | 1: fire when inside the window, 0: fire when outside |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | DATA_W | Last captured word |
| result_valid_o | output | 1 | One-cycle pulse for a new result |
| conv_irq_o | output | 1 | Conversion interrupt pulse |
| overrun_o | output | 1 | Sticky flag for a dropped trigger |
| cmp_fault_o | output | NUM_CMP | Per-comparator fault pulses |
| fault_irq_o | output | 1 | OR of comparator faults |

## Verification
The bench builds two instances from the same stimulus. Both use 12-bit words and four comparators. The first uses a 14-clock conversion, so the fixed maximum lead of 8 is the binding limit. The second uses a 6-clock conversion, so the CONV_CLKS-1 clamp of 5 is the limit actually reached. Driving both together exercises both branches of the lead clamp. It also shows the overrun trigger landing mid-conversion on a short and a long conversion at the same time.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_t;

    // Largest usable lead: bounded by the fixed maximum and by the conversion length.
    function automatic int unsigned lead_cap(input int unsigned max_lead,
                                             input int unsigned conv_clks);
        return (max_lead < conv_clks - 1) ? max_lead : conv_clks - 1;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int unsigned CONV_CLKS = 14,
    parameter int unsigned LEAD_MAX  = 8,
    parameter int unsigned LEAD_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              lead_en_i,
    input  logic [LEAD_W-1:0] lead_sel_i,
    output logic              busy_o,
    output logic              capture_o,
    output logic              done_o,
    output logic              irq_o,
    output logic              overrun_o
);

    localparam int unsigned CNT_W    = (CONV_CLKS > 2) ? $clog2(CONV_CLKS) : 1;
    localparam int unsigned LEAD_CAP = lead_cap(LEAD_MAX, CONV_CLKS);
    localparam logic [CNT_W-1:0] CNT_LOAD   = CNT_W'(CONV_CLKS - 1);
    localparam logic [CNT_W-1:0] LEAD_CAP_V = CNT_W'(LEAD_CAP);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, lead_q, lead_d;
    logic             start, last, irq_hit, drop;
    logic             done_q, irq_q, ovr_q;

    always_comb begin
        start   = (state_q == ST_IDLE) && trig_i;
        drop    = (state_q == ST_CONV) && trig_i;
        last    = (state_q == ST_CONV) && (cnt_q == '0);
        irq_hit = (state_q == ST_CONV) && (cnt_q == lead_q);
    end

    // Lead clamp, applied once at the START transition.
    always_comb begin
        if (!lead_en_i)
            lead_d = '0;
        else if (32'(lead_sel_i) > LEAD_CAP)
            lead_d = LEAD_CAP_V;
        else
            lead_d = CNT_W'(lead_sel_i);
    end

    // Next-state logic: START and FINISH transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig_i)      state_d = ST_CONV;
            ST_CONV: if (cnt_q == '0) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter and registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lead_q <= '0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (start) begin
                cnt_q  <= CNT_LOAD;
                lead_q <= lead_d;
            end else if ((state_q == ST_CONV) && (cnt_q != '0)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            done_q <= last;
            irq_q  <= irq_hit;
            ovr_q  <= ovr_q | drop;
        end
    end

    assign busy_o    = (state_q == ST_CONV);
    assign capture_o = last;
    assign done_o    = done_q;
    assign irq_o     = irq_q;
    assign overrun_o = ovr_q;

    // R2: an accepted trigger makes the block busy in the next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && trig_i) |=> busy_o);

    // R3: the result-valid strobe lasts a single cycle.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: with zero lead, the interrupt coincides with result valid.
    p_irq_nolead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_o && (lead_q == '0)) |=> (irq_o && done_o));

    // R7: a trigger while busy raises overrun.
    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_i) |=> overrun_o);

    // R7: overrun is sticky.
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

endmodule

// File: rtl/adc_win_cmp.sv
`timescale 1ns/1ps
module adc_win_cmp #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic              en_i,
    input  logic              inside_i,
    output logic              fault_o
);

    logic in_win, hit, fault_q;

    always_comb begin
        in_win = (data_i >= lo_i) && (data_i <= hi_i);
        hit    = en_i && (inside_i ? in_win : !in_win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= eval_i && hit;
    end

    assign fault_o = fault_q;

    // R9: a fault only follows an evaluation strobe.
    p_fault_on_eval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(eval_i));

    // R8: a disabled comparator never fires.
    p_fault_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(en_i));

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
    parameter int unsigned DATA_W    = 12,
    parameter int unsigned CONV_CLKS = 14,
    parameter int unsigned LEAD_MAX  = 8,
    parameter int unsigned NUM_CMP   = 4,
    localparam int unsigned LEAD_W   = $clog2(LEAD_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_i,
    input  logic                      lead_en_i,
    input  logic [LEAD_W-1:0]         lead_sel_i,
    input  logic [DATA_W-1:0]         sample_data_i,
    input  logic [NUM_CMP*DATA_W-1:0] cmp_lo_i,
    input  logic [NUM_CMP*DATA_W-1:0] cmp_hi_i,
    input  logic [NUM_CMP-1:0]        cmp_en_i,
    input  logic [NUM_CMP-1:0]        cmp_inside_i,
    output logic                      busy_o,
    output logic [DATA_W-1:0]         result_o,
    output logic                      result_valid_o,
    output logic                      conv_irq_o,
    output logic                      overrun_o,
    output logic [NUM_CMP-1:0]        cmp_fault_o,
    output logic                      fault_irq_o
);

    logic              capture;
    logic [DATA_W-1:0] result_q;

    adc_seq_timer #(
        .CONV_CLKS (CONV_CLKS),
        .LEAD_MAX  (LEAD_MAX),
        .LEAD_W    (LEAD_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .lead_en_i  (lead_en_i),
        .lead_sel_i (lead_sel_i),
        .busy_o     (busy_o),
        .capture_o  (capture),
        .done_o     (result_valid_o),
        .irq_o      (conv_irq_o),
        .overrun_o  (overrun_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       result_q <= '0;
        else if (capture) result_q <= sample_data_i;
    end
    assign result_o = result_q;

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        adc_win_cmp #(.DATA_W(DATA_W)) cmp_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .eval_i   (capture),
            .data_i   (sample_data_i),
            .lo_i     (cmp_lo_i[k*DATA_W +: DATA_W]),
            .hi_i     (cmp_hi_i[k*DATA_W +: DATA_W]),
            .en_i     (cmp_en_i[k]),
            .inside_i (cmp_inside_i[k]),
            .fault_o  (cmp_fault_o[k])
        );
    end

    assign fault_irq_o = |cmp_fault_o;

    // R9: comparator faults appear only alongside result valid.
    p_fault_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmp_fault_o) |-> result_valid_o);

    // R3: result only changes when a new result is announced.
    p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o));

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    localparam int DW  = 12;
    localparam int NC  = 4;
    localparam int CL  = 14;
    localparam int CS  = 6;
    localparam int LMX = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic          lead_en = 1'b0;
    logic [3:0]    lead_sel = '0;
    logic [DW-1:0] sdata = '0;
    logic [NC*DW-1:0] lo = '0, hi = '0;
    logic [NC-1:0] cen = '0, cins = '0;

    logic          busy_l, valid_l, irq_l, ovr_l, firq_l;
    logic [DW-1:0] res_l;
    logic [NC-1:0] flt_l;
    logic          busy_s, valid_s, irq_s, ovr_s, firq_s;
    logic [DW-1:0] res_s;
    logic [NC-1:0] flt_s;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_ovr = 1'b0;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.DATA_W(DW), .CONV_CLKS(CL), .LEAD_MAX(LMX), .NUM_CMP(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .lead_en_i(lead_en),
        .lead_sel_i(lead_sel), .sample_data_i(sdata), .cmp_lo_i(lo), .cmp_hi_i(hi),
        .cmp_en_i(cen), .cmp_inside_i(cins), .busy_o(busy_l), .result_o(res_l),
        .result_valid_o(valid_l), .conv_irq_o(irq_l), .overrun_o(ovr_l),
        .cmp_fault_o(flt_l), .fault_irq_o(firq_l));

    adc_seq_ctrl #(.DATA_W(DW), .CONV_CLKS(CS), .LEAD_MAX(LMX), .NUM_CMP(NC)) dut_short_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .lead_en_i(lead_en),
        .lead_sel_i(lead_sel), .sample_data_i(sdata), .cmp_lo_i(lo), .cmp_hi_i(hi),
        .cmp_en_i(cen), .cmp_inside_i(cins), .busy_o(busy_s), .result_o(res_s),
        .result_valid_o(valid_s), .conv_irq_o(irq_s), .overrun_o(ovr_s),
        .cmp_fault_o(flt_s), .fault_irq_o(firq_s));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_lead(input bit en, input int ls, input int conv);
        int v;
        if (!en) return 0;
        v = ls;
        if (v > LMX) v = LMX;
        if (v > conv - 1) v = conv - 1;
        return v;
    endfunction

    function automatic logic [NC-1:0] exp_fault(input logic [DW-1:0] d);
        logic [NC-1:0] f;
        for (int k = 0; k < NC; k++) begin
            logic inw;
            inw  = (d >= lo[k*DW +: DW]) && (d <= hi[k*DW +: DW]);
            f[k] = cen[k] && (cins[k] ? inw : !inw);
        end
        return f;
    endfunction

    task automatic set_cmp(input int k, input int l, input int h, input bit en, input bit ins);
        lo[k*DW +: DW] = DW'(l);
        hi[k*DW +: DW] = DW'(h);
        cen[k]  = en;
        cins[k] = ins;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trig  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_ovr = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy_l), 0);
        chk("R1 valid", int'(valid_l), 0);
        chk("R1 irq", int'(irq_l), 0);
        chk("R1 overrun", int'(ovr_l), 0);
        chk("R1 faults", int'(flt_l), 0);
        chk("R1 fault_irq", int'(firq_l), 0);
        chk("R1 short overrun", int'(ovr_s), 0);
    endtask

    // One conversion on both instances; observation j is after trigger edge + j.
    task automatic run_conv(input bit len, input logic [3:0] ls,
                            input logic [DW-1:0] d, input bit mid_trig);
        int eL, eS;
        logic [NC-1:0] ef;
        @(negedge clk);
        lead_en = len;
        lead_sel = ls;
        sdata = d;
        trig = 1'b1;
        eL = exp_lead(len, int'(ls), CL);
        eS = exp_lead(len, int'(ls), CS);
        ef = exp_fault(d);
        @(negedge clk);
        trig = 1'b0;
        // R6: lead controls change after the trigger edge and must not matter
        lead_en = 1'($urandom);
        lead_sel = 4'($urandom);
        for (int j = 0; j <= CL + 2; j++) begin
            chk("R2 busy", int'(busy_l), int'(j < CL));
            chk("R2 short busy", int'(busy_s), int'(j < CS));
            chk("R3 valid", int'(valid_l), int'(j == CL));
            chk("R3 short valid", int'(valid_s), int'(j == CS));
            chk(len ? "R5 R6 irq" : "R4 irq", int'(irq_l), int'(j == CL - eL));
            chk(len ? "R5 R6 short irq" : "R4 short irq", int'(irq_s), int'(j == CS - eS));
            chk("R8 R9 faults", int'(flt_l), (j == CL) ? int'(ef) : 0);
            chk("R9 short faults", int'(flt_s), (j == CS) ? int'(ef) : 0);
            chk("R9 fault_irq", int'(firq_l), int'((j == CL) && (ef != '0)));
            if (j >= CL) chk("R3 result", int'(res_l), int'(d));
            if (j >= CS) chk("R3 short result", int'(res_s), int'(d));
            if (j >= 4)  chk("R7 overrun", int'(ovr_l), int'(exp_ovr));
            if (j >= 4)  chk("R7 short overrun", int'(ovr_s), int'(exp_ovr));
            if (mid_trig && j == 3) begin
                trig = 1'b1;
                exp_ovr = 1'b1;
            end else begin
                trig = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R4 and R8: lead off; outside, inside-full, disabled, inclusive single point
        set_cmp(0, 100, 200, 1'b1, 1'b0);
        set_cmp(1, 0, 4095, 1'b1, 1'b1);
        set_cmp(2, 0, 4095, 1'b0, 1'b1);
        set_cmp(3, 50, 50, 1'b1, 1'b1);
        run_conv(1'b0, 4'd5, 12'd50, 1'b0);
        // R8: word equal to high limit counts as inside, so no outside fault
        run_conv(1'b1, 4'd8, 12'd200, 1'b0);
        // R8: word equal to low limit
        run_conv(1'b1, 4'd3, 12'd100, 1'b0);
        // R8: empty window (lo > hi): inside never, outside always
        set_cmp(0, 300, 200, 1'b1, 1'b0);
        set_cmp(1, 300, 200, 1'b1, 1'b1);
        run_conv(1'b1, 4'd0, 12'd250, 1'b0);
        // R5: lead beyond both caps
        run_conv(1'b1, 4'd15, 12'd4095, 1'b0);
        run_conv(1'b1, 4'd6, 12'd0, 1'b0);
        // R7: trigger while busy
        run_conv(1'b1, 4'd2, 12'd777, 1'b1);
        run_conv(1'b0, 4'd0, 12'd778, 1'b0);
        do_reset();

        for (int i = 0; i < 60; i++) begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            for (int k = 0; k < NC; k++) begin
                int a, b;
                a = int'(d) - int'($urandom_range(0, 40));
                b = int'(d) + int'($urandom_range(0, 40)) - 20;
                if (a < 0) a = 0;
                if (b < 0) b = 0;
                set_cmp(k, a, b, 1'($urandom), 1'($urandom));
            end
            run_conv(1'($urandom), 4'($urandom), d, ($urandom_range(0, 9) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule